// File: doc/BRIEF.md
# Transmitter Integrity Blink Trigger

This block watches four measurement and status feeds of a timing transmitter and forces the transmitter into a user-notification blink as soon as one of them is out of tolerance. The decision path is pure hardware: rule outcomes feed a latch that drives dedicated output lines. No software or communications path sits between a detected fault and the blink. The reaction time is therefore a fixed, small number of clock cycles, which is far inside the one-second budget.

Two of the rules average a signed phase error over a programmable window of 2^k samples and compare the magnitude of that average against a programmable tolerance. One rule checks the phase of the transmitted signal against the local epoch estimate. The other checks the phase error measured within the pulses. A third rule declares a missing RF return when no return strobe arrives within a programmable number of timing ticks. The fourth rule fires on a time-step flag from the reference clock. Each rule has its own enable. Once tripped, the blink stays on and keeps the rules that caused it until software clears it. The clear only takes effect while no enabled rule is active. One of three blink patterns is selected at trip time.

Top module: `blink_trigger`

## Requirements
- R1: After synchronous reset, `blink` is 0, `cause` is 4'b0000 and `pattern` is 2'b00.
- R2: A phase rule with window exponent k (values above MAXLOG are clamped to MAXLOG) takes 2^k valid samples. At the edge that accepts the last sample, its fault becomes |floor(sum / 2^k)| > tolerance. An average equal to the tolerance is not a fault. The fault is held until the next window completes.
- R3: The RF-return rule faults once `rf_timeout` ticks have been counted with no `rf_seen`. A cycle with `rf_seen` restarts the count and clears the fault, and takes priority over a tick in the same cycle.
- R4: A cycle with `ref_step` high makes the clock-step rule active in that cycle only.
- R5: A rule whose bit in `rule_en` is 0 never trips the blink. Bit 0 is epoch phase, bit 1 is pulse phase, bit 2 is missing RF return, and bit 3 is clock step.
- R6: `blink` rises at the first clock edge at which any enabled rule is active.
- R7: Once set, `blink` stays high until a cycle with `clear` high and no enabled rule active. Such a cycle returns `blink`, `cause` and `pattern` to 0. A `clear` while a rule is active is ignored.
- R8: `cause` captures exactly the set of enabled rules active in the tripping cycle, with the bit order of R5. It does not change while the blink is held.
- R9: `pattern` is the value of `pattern_sel` captured at the trip, except that 2'b11 is delivered as 2'b00. `pattern` never shows 2'b11 and is 2'b00 while not blinking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rule_en | input | 4 | Per-rule enable (bit order per R5) |
| epoch_valid | input | 1 | Epoch phase sample strobe |
| epoch_err | input | SW | Signed epoch phase error sample |
| epoch_log2len | input | LW | Epoch averaging window exponent |
| epoch_tol | input | SW | Epoch phase tolerance (magnitude) |
| pulse_valid | input | 1 | Pulse phase sample strobe |
| pulse_err | input | SW | Signed in-pulse phase error sample |
| pulse_log2len | input | LW | Pulse averaging window exponent |
| pulse_tol | input | SW | Pulse phase tolerance (magnitude) |
| rf_seen | input | 1 | RF return detected strobe |
| tick | input | 1 | Timeout counting tick |
| rf_timeout | input | TW | Ticks allowed without RF return |
| ref_step | input | 1 | Reference clock time-step flag |
| pattern_sel | input | 2 | Requested blink pattern |
| clear | input | 1 | Software clear request |
| blink | output | 1 | Blink active line |
| pattern | output | 2 | Blink pattern in effect |
| cause | output | 4 | Rules active at trip time |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is a software clear and an active rule. The bench holds the RF-return rule faulted, asserts `clear`, and expects the blink and its cause to survive. It then removes the fault with `rf_seen`, clears again, and expects everything to return to zero. The second pair is two rules tripping together. A clock-step pulse is driven in the very cycle the RF timeout expires, and `cause` must show both bits. A later fault must leave `cause` untouched. The phase rules are swept over window lengths, tolerances and sample ramps, and the expected trip is computed from a floor-divided sum.

// File: rtl/blink_pkg.sv
package blink_pkg;

    localparam int NRULE = 4;

    typedef enum logic [1:0] {
        RULE_EPOCH = 2'd0,
        RULE_PULSE = 2'd1,
        RULE_RF    = 2'd2,
        RULE_STEP  = 2'd3
    } rule_e;

    typedef logic [NRULE-1:0] rule_vec_t;

    typedef enum logic [1:0] {
        PAT_STEADY = 2'd0,
        PAT_SLOW   = 2'd1,
        PAT_FAST   = 2'd2
    } pattern_e;

    typedef struct packed {
        logic      blink;
        pattern_e  pat;
        rule_vec_t cause;
    } blink_state_t;

    // Reserved code 2'b11 falls back to the first pattern.
    function automatic pattern_e pat_map(input logic [1:0] sel);
        case (sel)
            2'd1:    return PAT_SLOW;
            2'd2:    return PAT_FAST;
            default: return PAT_STEADY;
        endcase
    endfunction

endpackage

// File: rtl/blink_phase_rule.sv
module blink_phase_rule #(
    parameter int SW     = 12,
    parameter int MAXLOG = 4,
    parameter int LW     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  logic signed [SW-1:0] sample,
    input  logic        [LW-1:0] log2len,
    input  logic        [SW-1:0] tol,
    output logic                 fault
);
    localparam int AW = SW + MAXLOG;
    localparam int CW = MAXLOG + 1;

    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] sum;
    logic signed [AW-1:0] avg;
    logic        [AW-1:0] mag;
    logic        [CW-1:0] cnt_q;
    logic        [CW-1:0] last;
    logic        [LW-1:0] k;
    logic                 fault_q;

    always_comb begin
        k    = (log2len > LW'(MAXLOG)) ? LW'(MAXLOG) : log2len;
        last = (CW'(1) << k) - CW'(1);
        sum  = acc_q + AW'(sample);
        avg  = sum >>> k;
        mag  = avg[AW-1] ? AW'(-avg) : AW'(avg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else if (valid) begin
            if (cnt_q >= last) begin
                acc_q   <= '0;
                cnt_q   <= '0;
                fault_q <= (mag > AW'(tol));
            end else begin
                acc_q <= sum;
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign fault = fault_q;

    // R2: the sample counter never runs past the window end
    a_r2_window_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= (CW'(1) << MAXLOG) - CW'(1));

    // R2: the fault only changes on a window-closing sample
    a_r2_fault_on_window: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(fault_q));

endmodule

// File: rtl/blink_rf_watch.sv
module blink_rf_watch #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rf_seen,
    input  logic          tick,
    input  logic [TW-1:0] timeout,
    output logic          fault
);
    logic [TW-1:0] cnt_q;

    assign fault = (cnt_q >= timeout);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (rf_seen) begin
            cnt_q <= '0;
        end else if (tick && !fault) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    // R3: a return strobe restarts the silence count
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        rf_seen |=> (cnt_q == '0));

    // R3: the count does not move without a tick
    a_r3_tick_only: assert property (@(posedge clk) disable iff (rst)
        (!tick && !rf_seen) |=> $stable(cnt_q));

endmodule

// File: rtl/blink_latch.sv
module blink_latch
    import blink_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  rule_vec_t    active,
    input  logic         clear,
    input  logic [1:0]   pattern_sel,
    output blink_state_t state
);
    blink_state_t st_q;
    logic         trip;

    assign trip = |active;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (!st_q.blink && trip) begin
            st_q.blink <= 1'b1;
            st_q.cause <= active;
            st_q.pat   <= pat_map(pattern_sel);
        end else if (st_q.blink && clear && !trip) begin
            st_q <= '0;
        end
    end

    assign state = st_q;

    // R6: an active rule always leaves the block blinking next cycle
    a_r6_trip: assert property (@(posedge clk) disable iff (rst)
        trip |=> st_q.blink);

    // R7: blink holds unless a clear arrives
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q.blink && !clear) |=> st_q.blink);

    // R8: cause is frozen while blinking
    a_r8_cause_frozen: assert property (@(posedge clk) disable iff (rst)
        st_q.blink |=> ($stable(st_q.cause) || !st_q.blink));

    // R8: a blink always has a recorded cause
    a_r8_cause_present: assert property (@(posedge clk) disable iff (rst)
        st_q.blink |-> (st_q.cause != '0));

    // R9: reserved pattern code never reaches the output
    a_r9_no_reserved: assert property (@(posedge clk) disable iff (rst)
        st_q.pat != 2'b11);

endmodule

// File: rtl/blink_trigger.sv
module blink_trigger
    import blink_pkg::*;
#(
    parameter int SW     = 12,
    parameter int MAXLOG = 4,
    parameter int TW     = 16,
    localparam int LW    = $clog2(MAXLOG + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NRULE-1:0]     rule_en,
    input  logic                 epoch_valid,
    input  logic signed [SW-1:0] epoch_err,
    input  logic        [LW-1:0] epoch_log2len,
    input  logic        [SW-1:0] epoch_tol,
    input  logic                 pulse_valid,
    input  logic signed [SW-1:0] pulse_err,
    input  logic        [LW-1:0] pulse_log2len,
    input  logic        [SW-1:0] pulse_tol,
    input  logic                 rf_seen,
    input  logic                 tick,
    input  logic        [TW-1:0] rf_timeout,
    input  logic                 ref_step,
    input  logic        [1:0]    pattern_sel,
    input  logic                 clear,
    output logic                 blink,
    output logic        [1:0]    pattern,
    output logic  [NRULE-1:0]    cause
);
    localparam int NPH = 2;

    logic                 ph_valid [NPH];
    logic signed [SW-1:0] ph_err   [NPH];
    logic        [LW-1:0] ph_len   [NPH];
    logic        [SW-1:0] ph_tol   [NPH];
    logic        [NPH-1:0] ph_fault;
    logic                 rf_fault;
    rule_vec_t            raw;
    rule_vec_t            active;
    blink_state_t         st;

    always_comb begin
        ph_valid[0] = epoch_valid;
        ph_err[0]   = epoch_err;
        ph_len[0]   = epoch_log2len;
        ph_tol[0]   = epoch_tol;
        ph_valid[1] = pulse_valid;
        ph_err[1]   = pulse_err;
        ph_len[1]   = pulse_log2len;
        ph_tol[1]   = pulse_tol;
    end

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        blink_phase_rule #(
            .SW(SW), .MAXLOG(MAXLOG), .LW(LW)
        ) i_rule (
            .clk     (clk),
            .rst     (rst),
            .valid   (ph_valid[g]),
            .sample  (ph_err[g]),
            .log2len (ph_len[g]),
            .tol     (ph_tol[g]),
            .fault   (ph_fault[g])
        );
    end

    blink_rf_watch #(.TW(TW)) i_rf (
        .clk     (clk),
        .rst     (rst),
        .rf_seen (rf_seen),
        .tick    (tick),
        .timeout (rf_timeout),
        .fault   (rf_fault)
    );

    always_comb begin
        raw             = '0;
        raw[RULE_EPOCH] = ph_fault[0];
        raw[RULE_PULSE] = ph_fault[1];
        raw[RULE_RF]    = rf_fault;
        raw[RULE_STEP]  = ref_step;
        active          = raw & rule_en;
    end

    blink_latch i_latch (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .clear       (clear),
        .pattern_sel (pattern_sel),
        .state       (st)
    );

    assign blink   = st.blink;
    assign pattern = st.pat;
    assign cause   = st.cause;

    // R5: a disabled rule never appears as a cause of a fresh trip
    a_r5_mask: assert property (@(posedge clk) disable iff (rst)
        $rose(blink) |-> ((cause & ~$past(rule_en)) == '0));

    // R9: idle output shows the default pattern
    a_r9_idle_pattern: assert property (@(posedge clk) disable iff (rst)
        !blink |-> (pattern == 2'b00));

endmodule

// File: tb/test_blink_trigger.sv
module test_blink_trigger;
    localparam int SW = 12;
    localparam int MAXLOG = 4;
    localparam int TW = 16;
    localparam int LW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] rule_en = '0;
    logic epoch_valid = 1'b0, pulse_valid = 1'b0;
    logic signed [SW-1:0] epoch_err = '0, pulse_err = '0;
    logic [LW-1:0] epoch_log2len = '0, pulse_log2len = '0;
    logic [SW-1:0] epoch_tol = '0, pulse_tol = '0;
    logic rf_seen = 1'b0, tick = 1'b0, ref_step = 1'b0, clear = 1'b0;
    logic [TW-1:0] rf_timeout = 16'd3;
    logic [1:0] pattern_sel = '0;
    logic blink;
    logic [1:0] pattern;
    logic [3:0] cause;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    blink_trigger #(.SW(SW), .MAXLOG(MAXLOG), .TW(TW)) i_blink_trigger (
        .clk(clk), .rst(rst), .rule_en(rule_en),
        .epoch_valid(epoch_valid), .epoch_err(epoch_err),
        .epoch_log2len(epoch_log2len), .epoch_tol(epoch_tol),
        .pulse_valid(pulse_valid), .pulse_err(pulse_err),
        .pulse_log2len(pulse_log2len), .pulse_tol(pulse_tol),
        .rf_seen(rf_seen), .tick(tick), .rf_timeout(rf_timeout),
        .ref_step(ref_step), .pattern_sel(pattern_sel), .clear(clear),
        .blink(blink), .pattern(pattern), .cause(cause)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rule_en = '0; epoch_valid = 0; pulse_valid = 0;
        rf_seen = 0; tick = 0; ref_step = 0; clear = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R2, R5, R6, R8: one averaging window on one phase rule
    task automatic phase_trial(input int rule, input int k, input int tol,
                               input int base, input int step);
        int sum = 0;
        int avg;
        bit exp_f;
        do_reset();
        rule_en = 4'(1 << rule);
        epoch_log2len = LW'(k); pulse_log2len = LW'(k);
        epoch_tol = SW'(tol); pulse_tol = SW'(tol);
        for (int i = 0; i < (1 << k); i++) begin
            @(negedge clk);
            if (rule == 0) begin epoch_valid = 1; epoch_err = SW'(base + i*step); end
            else begin pulse_valid = 1; pulse_err = SW'(base + i*step); end
            sum += base + i*step;
        end
        @(negedge clk);
        epoch_valid = 0; pulse_valid = 0;
        @(negedge clk);
        avg = sum >>> k;
        if (avg < 0) avg = -avg;
        exp_f = (avg > tol);
        chk("R2 window trip", int'(blink), int'(exp_f));
        chk("R8 phase cause", int'(cause), exp_f ? (1 << rule) : 0);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int bases[4] = '{-30, -7, 3, 18};
        int tols[3]  = '{0, 5, 20};
        do_reset();
        // R1: reset state
        chk("R1 blink", int'(blink), 0);
        chk("R1 cause", int'(cause), 0);
        chk("R1 pattern", int'(pattern), 0);

        // R2 sweep on the epoch rule
        for (int k = 0; k < 4; k++)
            for (int t = 0; t < 3; t++)
                for (int b = 0; b < 4; b++)
                    phase_trial(0, k, tols[t], bases[b], (b % 2) ? 3 : -2);
        // R2 on the pulse rule, including clamped exponent and equality edge
        phase_trial(1, 1, 10, 10, 0);
        phase_trial(1, 1, 9, 10, 0);
        phase_trial(1, 2, 4, -5, 0);
        phase_trial(1, 7, 6, 5, 1);

        // R5: faulted phase rule but disabled -> no blink
        do_reset();
        rule_en = 4'b0000; epoch_log2len = 0; epoch_tol = 0;
        @(negedge clk); epoch_valid = 1; epoch_err = 12'sd50;
        @(negedge clk); epoch_valid = 0;
        @(negedge clk);
        chk("R5 disabled epoch", int'(blink), 0);
        @(negedge clk); ref_step = 1;
        @(negedge clk); ref_step = 0;
        chk("R5 disabled step", int'(blink), 0);

        // R4, R6, R9: step rule, one-cycle reaction, pattern sweep
        for (int p = 0; p < 4; p++) begin
            do_reset();
            rule_en = 4'b1000; pattern_sel = 2'(p);
            @(negedge clk); ref_step = 1;
            chk("R6 before edge", int'(blink), 0);
            @(negedge clk); ref_step = 0; pattern_sel = 2'(3 - p);
            chk("R4 step trip", int'(blink), 1);
            chk("R9 pattern", int'(pattern), (p == 3) ? 0 : p);
            @(negedge clk);
            chk("R9 pattern held", int'(pattern), (p == 3) ? 0 : p);
            clear = 1;
            @(negedge clk); clear = 0;
            chk("R7 cleared", int'(blink), 0);
            chk("R9 idle pattern", int'(pattern), 0);
        end

        // R3: RF timeout of 3 ticks, restart on strobe, strobe beats tick
        do_reset();
        rule_en = 4'b0100; rf_timeout = 16'd3;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
        @(negedge clk); tick = 1; rf_seen = 1;
        @(negedge clk); tick = 0; rf_seen = 0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
        @(negedge clk);
        chk("R3 restart no trip", int'(blink), 0);
        tick = 1;
        @(negedge clk); tick = 0;
        chk("R3 not before edge", int'(blink), 0);
        @(negedge clk);
        chk("R3 timeout trip", int'(blink), 1);
        chk("R3 cause", int'(cause), 4'b0100);

        // R7: clear with rule active is ignored; R8: later fault leaves cause
        clear = 1; ref_step = 1; rule_en = 4'b1100;
        @(negedge clk); clear = 0; ref_step = 0;
        chk("R7 clear ignored", int'(blink), 1);
        chk("R8 cause frozen", int'(cause), 4'b0100);
        rf_seen = 1;
        @(negedge clk); rf_seen = 0; clear = 1;
        @(negedge clk); clear = 0;
        chk("R7 clear accepted", int'(blink), 0);
        chk("R7 cause zeroed", int'(cause), 0);

        // R8: two rules in the same cycle
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0; ref_step = 1;
        @(negedge clk); ref_step = 0;
        chk("R8 joint trip", int'(blink), 1);
        chk("R8 joint cause", int'(cause), 4'b1100);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule